// File: doc/BRIEF.md
# Processor Core Power-Up Sequencer

This block brings one processor core out of power collapse. When a boot request arrives and the core has never been started, the block waits for the cluster cache domain to report that it is powered. It then runs a fixed chain of core power-control words that handles sleep exit, memory clamp, non-retention and retention enables, a wordline clock pulse, the logic clamp, the reset and the power-up acknowledge. One step of the chain also writes a power-gate control word that closes the core logic head switch. Each timed step is held for a set number of microseconds, measured by a cycle counter.

A sticky cold-boot flag is set when the chain finishes. Any later boot request skips the chain and only produces a one-cycle core-release pulse. The cache domain may report a failure, or may not come up within a timeout. In either case the block raises a one-cycle error, leaves both control words at their reset value and keeps the flag clear.

Top module: `core_pwr_seq`

## Requirements
- R1: After a synchronous active-low reset, `core_ctl` and `gate_ctl` are 0, and `core_release`, `boot_err`, `busy` and `cold_done` are all low.
- R2: A cold boot drives `core_ctl` through 0x33, 0x31, 0x39, 0x239, 0x4239, 0x239, 0x238, 0x208 and 0x288, in that order. `gate_ctl` changes to 0x10000001 while `core_ctl` is 0x33.
- R3: With W = 2*CYC_PER_US cycles, each value of `core_ctl` holds for the following number of clock cycles: 0x33 for W+2; 0x31 for 1; 0x39, 0x239 and 0x4239 for W+1 each; the second 0x239 for 1; 0x238 for W+1; 0x208 for 1.
- R4: No control word changes before `cache_ready` is seen. A cold boot request made while the cache is not ready sets `busy` and waits.
- R5: The block may wait TMO_CYC cycles without seeing `cache_ready` or `cache_fail`. In that case `boot_err` pulses for one cycle in the TMO_CYC-th cycle after the request was sampled. The control words stay 0, `cold_done` stays clear and the block returns to idle.
- R6: `cache_fail` may be seen at the cold request or during the wait. In that case `boot_err` pulses for one cycle in the next cycle, and the control words and `cold_done` are left untouched.
- R7: `core_release` is high for exactly one cycle, in the first cycle that `core_ctl` shows 0x288. `cold_done` is set from that cycle on.
- R8: When `cold_done` is set, a boot request gives a one-cycle `core_release` in the cycle after it is sampled. This does not depend on `cache_ready` and leaves both control words unchanged.
- R9: A boot request sampled while `busy` is high is ignored. It neither changes the chain nor adds a release pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_req | input | 1 | Boot request, sampled on each rising edge |
| cache_ready | input | 1 | Cluster cache domain reports powered |
| cache_fail | input | 1 | Cluster cache bring-up failed |
| core_ctl | output | 32 | Core power-control word |
| gate_ctl | output | 32 | Core power-gate control word |
| core_release | output | 1 | One-cycle core release pulse |
| boot_err | output | 1 | One-cycle error pulse |
| busy | output | 1 | Sequencer is not idle |
| cold_done | output | 1 | Sticky flag: full unclamp has completed |

## Verification
The assertions take the inputs to be synchronous to `clk`. They also take `cache_fail` to win whenever it is seen together with `cache_ready`, and a request to be a level sampled on each edge. The bench changes every input only on falling edges. It raises `cache_ready` or `cache_fail` only after a random delay shorter than the timeout, or holds it low until the timeout expires. It never asserts the two cache inputs together. It sends random extra requests during the chain so that they land while `busy` is high.

// File: rtl/core_pwr_pkg.sv
// core_pwr_pkg: shared types and the fixed unclamp step table.
// Assumes the step index is below NSTEPS; other indexes return the final step.
package core_pwr_pkg;

    localparam int NSTEPS      = 10;
    localparam int IDX_W       = $clog2(NSTEPS);
    localparam int MAX_WAIT_US = 2;
    localparam logic [31:0] GATE_ON = 32'h1000_0001;
    localparam logic [31:0] CORE_UP = 32'h0000_0288;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_STEP, ST_HOLD, ST_REL
    } seq_state_e;

    typedef struct packed {
        logic [31:0] core_val;
        logic        gate_we;
        logic [3:0]  wait_us;
    } step_t;

    // Returns the control value, the gate write flag and the wait for one step.
    function automatic step_t step_of(input logic [IDX_W-1:0] idx);
        step_t s;
        case (idx)
            4'd0:    s = '{32'h0000_0033, 1'b0, 4'd0};
            4'd1:    s = '{32'h0000_0033, 1'b1, 4'd2};
            4'd2:    s = '{32'h0000_0031, 1'b0, 4'd0};
            4'd3:    s = '{32'h0000_0039, 1'b0, 4'd2};
            4'd4:    s = '{32'h0000_0239, 1'b0, 4'd2};
            4'd5:    s = '{32'h0000_4239, 1'b0, 4'd2};
            4'd6:    s = '{32'h0000_0239, 1'b0, 4'd0};
            4'd7:    s = '{32'h0000_0238, 1'b0, 4'd2};
            4'd8:    s = '{32'h0000_0208, 1'b0, 4'd0};
            default: s = '{CORE_UP,       1'b0, 4'd0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/core_pwr_step_rom.sv
// core_pwr_step_rom: decodes a step index into the control value, the gate
// write enable and the wait length in clock cycles.
// Assumes CYC_PER_US*MAX_WAIT_US fits in CW bits.
module core_pwr_step_rom #(
    parameter int CYC_PER_US = 100,
    parameter int CW         = 8
) (
    input  logic [core_pwr_pkg::IDX_W-1:0] idx,
    output logic [31:0]                    core_val,
    output logic                           gate_we,
    output logic                           has_wait,
    output logic [CW-1:0]                  wait_cyc
);
    import core_pwr_pkg::*;

    step_t cur;

    // Combinational lookup of the current step.
    always_comb begin
        cur      = step_of(idx);
        core_val = cur.core_val;
        gate_we  = cur.gate_we;
        has_wait = (cur.wait_us != 4'd0);
        wait_cyc = CW'(32'(cur.wait_us) * 32'(CYC_PER_US));
    end
endmodule

// File: rtl/core_pwr_us_timer.sv
// core_pwr_us_timer: loadable down-counter shared by the step waits and the
// cache-ready timeout. done is high when the count is zero.
// Assumes load values are already reduced by one by the caller.
module core_pwr_us_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - CW'(1);
    end

    assign done = (cnt == '0);

    // R3
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (done == ($past(load_val) == '0)));
endmodule

// File: rtl/core_pwr_seq.sv
// core_pwr_seq: releases one core from power collapse. The first boot runs the
// full unclamp chain after the cache domain is ready. Later boots only pulse
// core_release. Assumes synchronous inputs; cache_fail wins over cache_ready.
module core_pwr_seq #(
    parameter int CYC_PER_US = 100,
    parameter int TMO_CYC    = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        boot_req,
    input  logic        cache_ready,
    input  logic        cache_fail,
    output logic [31:0] core_ctl,
    output logic [31:0] gate_ctl,
    output logic        core_release,
    output logic        boot_err,
    output logic        busy,
    output logic        cold_done
);
    import core_pwr_pkg::*;

    localparam int WAIT_MAX = MAX_WAIT_US * CYC_PER_US;
    localparam int CNT_MAX  = (TMO_CYC > WAIT_MAX) ? TMO_CYC : WAIT_MAX;
    localparam int CW       = $clog2(CNT_MAX + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSTEPS - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [31:0]      core_q, gate_q;
    logic             cold_q, err_q;
    logic [31:0]      rom_core;
    logic             rom_gate_we, rom_has_wait;
    logic [CW-1:0]    rom_wait;
    logic             tmr_load, tmr_done;
    logic [CW-1:0]    tmr_val;
    logic             start_wait;

    core_pwr_step_rom #(.CYC_PER_US(CYC_PER_US), .CW(CW)) u_rom (
        .idx(idx), .core_val(rom_core), .gate_we(rom_gate_we),
        .has_wait(rom_has_wait), .wait_cyc(rom_wait)
    );

    core_pwr_us_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .done(tmr_done)
    );

    // Pick the timer load: a timeout on entering the wait, a step wait in STEP.
    always_comb begin
        start_wait = (state == ST_IDLE) && boot_req && !cold_q
                     && !cache_fail && !cache_ready;
        tmr_load   = start_wait || ((state == ST_STEP) && rom_has_wait);
        tmr_val    = start_wait ? CW'(TMO_CYC - 1) : (rom_wait - CW'(1));
    end

    // Main sequencing: idle, cache wait, step write, step hold, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            core_q <= '0;
            gate_q <= '0;
            cold_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state)
                ST_IDLE: if (boot_req) begin
                    if (cold_q)           state <= ST_REL;
                    else if (cache_fail)  err_q <= 1'b1;
                    else if (cache_ready) begin state <= ST_STEP; idx <= '0; end
                    else                  state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (cache_fail)       begin err_q <= 1'b1; state <= ST_IDLE; end
                    else if (cache_ready) begin state <= ST_STEP; idx <= '0; end
                    else if (tmr_done)    begin err_q <= 1'b1; state <= ST_IDLE; end
                end
                ST_STEP: begin
                    core_q <= rom_core;
                    if (rom_gate_we) gate_q <= GATE_ON;
                    if (rom_has_wait)          state <= ST_HOLD;
                    else if (idx == LAST_IDX)  begin state <= ST_REL; cold_q <= 1'b1; end
                    else                       idx <= idx + IDX_W'(1);
                end
                ST_HOLD: if (tmr_done) begin
                    idx   <= idx + IDX_W'(1);
                    state <= ST_STEP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign core_ctl     = core_q;
    assign gate_ctl     = gate_q;
    assign core_release = (state == ST_REL);
    assign boot_err     = err_q;
    assign busy         = (state != ST_IDLE);
    assign cold_done    = cold_q;

    // R7
    release_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_release |-> (core_ctl == CORE_UP) && cold_done);
    // R7
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_release |=> !core_release);
    // R5
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |=> !boot_err);
    // R6
    err_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |-> (core_ctl == '0) && (gate_ctl == '0) && !cold_done);
    // R2
    gate_before_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ctl == 32'h31 && $past(core_ctl) != 32'h31)
        |-> ($past(core_ctl) == 32'h33) && (gate_ctl == GATE_ON));
    // R4
    ready_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(core_ctl) == '0 && core_ctl != '0) |-> $past(cache_ready, 2));
    // R8
    cold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cold_done |=> cold_done);
endmodule

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb;
    localparam int CPU = 4;
    localparam int TMO = 40;
    localparam int W   = 2 * CPU;

    logic clk = 1'b0;
    logic rst_n, boot_req, cache_ready, cache_fail;
    logic [31:0] core_ctl, gate_ctl;
    logic core_release, boot_err, busy, cold_done;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    core_pwr_seq #(.CYC_PER_US(CPU), .TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_req(boot_req), .cache_ready(cache_ready),
        .cache_fail(cache_fail), .core_ctl(core_ctl), .gate_ctl(gate_ctl),
        .core_release(core_release), .boot_err(boot_err), .busy(busy),
        .cold_done(cold_done)
    );

    function automatic logic [31:0] exp_val(input int i);
        case (i)
            0: return 32'h33;   1: return 32'h31;   2: return 32'h39;
            3: return 32'h239;  4: return 32'h4239; 5: return 32'h239;
            6: return 32'h238;  default: return 32'h208;
        endcase
    endfunction

    function automatic int exp_len(input int i);
        case (i)
            0: return W + 2;
            1, 5, 7: return 1;
            default: return W + 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic pulse_req();
        @(negedge clk) boot_req = 1'b1;
        @(negedge clk) boot_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        check(core_ctl == 0 && gate_ctl == 0, "R1 words", core_ctl, 0);
        check({core_release, boot_err, busy, cold_done} == 4'b0, "R1 flags",
              {core_release, boot_err, busy, cold_done}, 0);
    endtask

    // Follows a cold chain from the current cycle until 0x288 shows up.
    task automatic run_trace(input bit noisy);
        logic [31:0] vals [8];
        int lens [8];
        int n = 0, len = 0;
        logic [31:0] prev = core_ctl;
        logic [31:0] at_gate = 0;
        bit rel_bad = 0, rel_ok = 0, done = 0;
        for (int c = 0; c < 4000 && !done; c++) begin
            @(negedge clk);
            boot_req = noisy ? ($urandom % 3 == 0) : 1'b0;
            if (gate_ctl == 32'h1000_0001 && at_gate == 0) at_gate = core_ctl;
            if (core_release && core_ctl != 32'h288) rel_bad = 1;
            if (core_ctl != prev) begin
                if (prev != 0 && n < 8) begin vals[n] = prev; lens[n] = len; n++; end
                prev = core_ctl; len = 1;
                if (core_ctl == 32'h288) begin rel_ok = core_release; done = 1; end
            end else len++;
        end
        boot_req = 1'b0;
        // R2
        check(n == 8, "R2 step count", n, 8);
        for (int i = 0; i < n; i++) begin
            check(vals[i] == exp_val(i), "R2 value order", vals[i], exp_val(i));
            // R3
            check(lens[i] == exp_len(i), "R3 hold cycles", lens[i], exp_len(i));
        end
        check(at_gate == 32'h33, "R2 gate during 0x33", at_gate, 32'h33);
        // R7
        check(rel_ok && !rel_bad, "R7 release at ack", {rel_ok, rel_bad}, 2'b10);
        @(negedge clk);
        check(!core_release && cold_done, "R7 pulse end/cold", {core_release, cold_done}, 2'b01);
        // R9
        begin
            bit extra = 0;
            repeat (10) begin @(negedge clk); if (core_release) extra = 1; end
            check(!extra && !busy, "R9 ignored requests", {extra, busy}, 0);
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; boot_req = 0; cache_ready = 0; cache_fail = 0;
        do_reset();

        // R5 timeout with cache never ready
        pulse_req();
        check(busy == 1'b1, "R4 busy while waiting", busy, 1);
        repeat (TMO - 1) @(negedge clk);
        check(!boot_err && core_ctl == 0, "R4 no change before ready", {boot_err, core_ctl}, 0);
        @(negedge clk);
        check(boot_err == 1'b1, "R5 timeout error", boot_err, 1);
        check(core_ctl == 0 && gate_ctl == 0, "R5 words untouched", core_ctl, 0);
        @(negedge clk);
        check(!boot_err && !busy && !cold_done, "R5 back idle", {boot_err, busy, cold_done}, 0);

        // R6 fail at request
        @(negedge clk) cache_fail = 1'b1;
        pulse_req();
        check(boot_err == 1'b1 && !busy, "R6 fail at request", {boot_err, busy}, 2'b10);
        cache_fail = 1'b0;

        // R6 fail during wait
        pulse_req();
        repeat (1 + $urandom % (TMO - 4)) @(negedge clk);
        cache_fail = 1'b1;
        @(negedge clk) cache_fail = 1'b0;
        check(boot_err == 1'b1, "R6 fail during wait", boot_err, 1);
        check(core_ctl == 0 && gate_ctl == 0 && !cold_done, "R6 untouched", core_ctl, 0);

        // R4 random ready delay, then the full chain with noisy requests (R9)
        pulse_req();
        begin
            bit moved = 0;
            repeat (1 + $urandom % (TMO - 6)) begin
                @(negedge clk); if (core_ctl != 0) moved = 1;
            end
            check(!moved, "R4 held until ready", moved, 0);
        end
        cache_ready = 1'b1;
        run_trace(1'b1);

        // R8 warm boots
        for (int k = 0; k < 6; k++) begin
            cache_ready = $urandom % 2;
            repeat ($urandom % 5) @(negedge clk);
            pulse_req();
            check(core_release == 1'b1, "R8 warm release", core_release, 1);
            check(core_ctl == 32'h288 && gate_ctl == 32'h1000_0001, "R8 words kept", core_ctl, 32'h288);
            @(negedge clk);
            check(!core_release && !busy, "R8 single pulse", {core_release, busy}, 0);
        end

        // R1 reset clears the flag; then a cold boot with the cache already ready
        do_reset();
        cache_ready = 1'b1;
        @(negedge clk) boot_req = 1'b1;
        run_trace(1'b0);

        finish_run();
    end
endmodule